// File: doc/BRIEF.md
# Cycle-Stealing DMA Channel

This block is a single DMA channel that copies a programmed number of bytes from a peripheral into memory while leaving the processor in charge of the bus. It does not hold the bus for a whole block. For each byte it waits for the peripheral to request service, raises a hold request, and waits for the processor to grant the bus. It then runs one fly-by cycle, in which the I/O read strobe and the memory write strobe are active together for a fixed memory-cycle length. After that it releases the bus again. A block of N bytes therefore costs the processor N short bus grants instead of one long one.

A controller loads the start address and byte count with a one-cycle start pulse. The channel keeps its own address and remaining-count registers. It flags terminal count when the last byte is written, and it raises a completion level that stays high until the next start.

Top module: `cs_dma_channel`

## Requirements
- R1: While reset is applied, and after it is released, the channel is idle: hold_req, per_ack, io_rd, mem_wr, busy, done and tc are all 0.
- R2: A start pulse in the idle state with a nonzero count loads start_addr into mem_addr and start_count into remaining, clears done, and sets busy from the next cycle.
- R3: hold_req rises only in the cycle after per_req was sampled high while the channel waits for a request. It stays low while the channel is idle, even when per_req is high.
- R4: Once hold_req is high, no strobe (per_ack, io_rd, mem_wr) is asserted until hold_ack has been sampled high. hold_req stays high while the channel waits.
- R5: Each byte transfer keeps per_ack, io_rd and mem_wr high together for exactly MEM_CYC consecutive cycles (default 10). During that time mem_addr is stable and mem_data equals io_data. Outside a transfer mem_data is 0.
- R6: After each byte, mem_addr increases by one (wrapping modulo 2^ADDR_W) and remaining decreases by one.
- R7: hold_req is low in the cycle right after the last write cycle of every byte. This is true even when per_req stays high. A block of N bytes produces exactly N rising edges of hold_req.
- R8: tc goes high in the release cycle of the last byte. In the following cycle busy is 0 and done is 1. Both stay high until the next start, which clears them.
- R9: A start with count 0 sets done and tc in the next cycle and causes no hold request.
- R10: A start pulse while busy is ignored: mem_addr and remaining are unchanged and the block finishes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that loads address and count |
| start_addr | input | ADDR_W | First memory address of the block |
| start_count | input | CNT_W | Number of bytes to move |
| per_req | input | 1 | Peripheral service request, one per byte |
| per_ack | output | 1 | Peripheral acknowledge, high during the byte's transfer |
| hold_req | output | 1 | Bus request to the processor |
| hold_ack | input | 1 | Bus grant from the processor |
| io_rd | output | 1 | I/O read strobe to the peripheral |
| io_data | input | DATA_W | Byte driven by the peripheral |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Current memory address |
| mem_data | output | DATA_W | Write data, io_data during a transfer, else 0 |
| remaining | output | CNT_W | Bytes still to move |
| busy | output | 1 | Block in progress |
| done | output | 1 | Block completed, held until next start |
| tc | output | 1 | Terminal count reached |

## Verification
The block is driven through a range of request and grant patterns. With an immediate request and an immediate grant, the basic per-byte sequence is visible. Delaying the peripheral request shows that no hold is raised without it. Delaying the grant shows that the strobes wait for ownership of the bus. Holding the peripheral request high the whole time shows that the bus is still released after every byte. A block that starts at the top address separates correct wrap-around from carry leakage. Single-byte blocks and zero-count blocks check terminal count and completion at their edges. A start during a transfer and a reset during a transfer check that neither corrupts an active block nor leaves a strobe driven.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_WAIT_GRANT,
        ST_MOVE,
        ST_RELEASE
    } dma_state_e;

endpackage

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
    import cs_dma_pkg::*;
#(
    parameter int MEM_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic load_zero,
    input  logic cnt_zero,
    input  logic per_req,
    input  logic hold_ack,
    output logic load,
    output logic step,
    output logic hold_req,
    output logic xfer,
    output logic busy,
    output logic done
);

    localparam int TW = (MEM_CYC > 1) ? $clog2(MEM_CYC) : 1;

    typedef struct packed {
        dma_state_e     st;
        logic [TW-1:0]  tmr;
        logic           done;
    } seq_t;

    seq_t q, d;

    always_comb begin
        d    = q;
        load = 1'b0;
        step = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    load   = 1'b1;
                    d.done = load_zero;
                    if (!load_zero) d.st = ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (per_req) d.st = ST_WAIT_GRANT;
            end
            ST_WAIT_GRANT: begin
                if (hold_ack) begin
                    d.st  = ST_MOVE;
                    d.tmr = TW'(MEM_CYC - 1);
                end
            end
            ST_MOVE: begin
                if (q.tmr == '0) begin
                    step = 1'b1;
                    d.st = ST_RELEASE;
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_RELEASE: begin
                if (cnt_zero) begin
                    d.st   = ST_IDLE;
                    d.done = 1'b1;
                end else begin
                    d.st = ST_WAIT_REQ;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.tmr  <= '0;
            q.done <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign hold_req = (q.st == ST_WAIT_GRANT) || (q.st == ST_MOVE);
    assign xfer     = (q.st == ST_MOVE);
    assign busy     = (q.st != ST_IDLE);
    assign done     = q.done;

    // cycle counter for the write-length window
    logic [TW:0] wr_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    wr_len_q <= '0;
        else if (xfer) wr_len_q <= wr_len_q + 1'b1;
        else           wr_len_q <= '0;
    end

    // R5: every transfer lasts exactly MEM_CYC cycles
    a_r5_write_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer) |-> (wr_len_q == (TW+1)'(MEM_CYC)));

    // R4: a transfer begins only after the grant was seen
    a_r4_grant_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer) |-> $past(hold_ack));

    // R3: a hold request follows a sampled peripheral request
    a_r3_req_first: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_req) |-> $past(per_req));

    // R7: the bus is released right after a write
    a_r7_release_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold_req) |-> $past(xfer));

    // R4: strobes only while the bus is requested
    a_r4_xfer_holds: assert property (@(posedge clk) disable iff (!rst_n)
        xfer |-> hold_req);

endmodule

// File: rtl/cs_dma_regs.sv
module cs_dma_regs #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [CNT_W-1:0]  cnt_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              tc_q
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              tc;
    } regs_t;

    regs_t q, d;

    always_comb begin
        d = q;
        if (load) begin
            d.addr = addr_in;
            d.cnt  = cnt_in;
            d.tc   = (cnt_in == '0);
        end else if (step) begin
            d.addr = q.addr + 1'b1;
            d.cnt  = q.cnt - 1'b1;
            d.tc   = (q.cnt == CNT_W'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.addr <= '0;
            q.cnt  <= '0;
            q.tc   <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign addr_q = q.addr;
    assign cnt_q  = q.cnt;
    assign tc_q   = q.tc;

    // R6: a step advances address and count by one
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (addr_q == ADDR_W'($past(addr_q) + 1'b1))
              && (cnt_q == CNT_W'($past(cnt_q) - 1'b1)));

    // R6: the count never steps below zero
    a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (cnt_q != '0));

endmodule

// File: rtl/cs_dma_channel.sv
module cs_dma_channel #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 10,
    parameter int DATA_W  = 8,
    parameter int MEM_CYC = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [CNT_W-1:0]  start_count,
    input  logic              per_req,
    output logic              per_ack,
    output logic              hold_req,
    input  logic              hold_ack,
    output logic              io_rd,
    input  logic [DATA_W-1:0] io_data,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic [CNT_W-1:0]  remaining,
    output logic              busy,
    output logic              done,
    output logic              tc
);

    logic load, step, xfer;

    cs_dma_seq #(
        .MEM_CYC (MEM_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .load_zero (start_count == '0),
        .cnt_zero  (remaining == '0),
        .per_req   (per_req),
        .hold_ack  (hold_ack),
        .load      (load),
        .step      (step),
        .hold_req  (hold_req),
        .xfer      (xfer),
        .busy      (busy),
        .done      (done)
    );

    cs_dma_regs #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .addr_in (start_addr),
        .cnt_in  (start_count),
        .addr_q  (mem_addr),
        .cnt_q   (remaining),
        .tc_q    (tc)
    );

    assign per_ack  = xfer;
    assign io_rd    = xfer;
    assign mem_wr   = xfer;
    assign mem_data = xfer ? io_data : '0;

    // R8: completion and terminal count agree once idle
    a_r8_done_tc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (tc && !busy));

endmodule

// File: tb/cs_dma_channel_tb.sv
module cs_dma_channel_tb;

    localparam int AW = 16;
    localparam int CW = 10;
    localparam int DW = 8;
    localparam int MC = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] s_addr = '0;
    logic [CW-1:0] s_cnt = '0;
    logic          per_req = 1'b0;
    logic          hold_ack = 1'b0;
    logic [DW-1:0] io_data = '0;
    logic          per_ack, hold_req, io_rd, mem_wr, busy, done, tc;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_data;
    logic [CW-1:0] remaining;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int hold_rises = 0;
    logic hold_prev = 1'b0;

    cs_dma_channel #(
        .ADDR_W (AW), .CNT_W (CW), .DATA_W (DW), .MEM_CYC (MC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .start_addr (s_addr),
        .start_count (s_cnt), .per_req (per_req), .per_ack (per_ack),
        .hold_req (hold_req), .hold_ack (hold_ack), .io_rd (io_rd),
        .io_data (io_data), .mem_wr (mem_wr), .mem_addr (mem_addr),
        .mem_data (mem_data), .remaining (remaining), .busy (busy),
        .done (done), .tc (tc)
    );

    always #2 clk = ~clk;

    // vector: {addr[16], count[10], req_gap[4], grant_gap[4], keep_req[1]}
    localparam logic [34:0] VEC [6] = '{
        {16'h0100, 10'd3, 4'd0, 4'd0, 1'b0},
        {16'h0040, 10'd2, 4'd3, 4'd0, 1'b0},
        {16'h1234, 10'd2, 4'd0, 4'd4, 1'b0},
        {16'h0800, 10'd4, 4'd0, 4'd0, 1'b1},
        {16'hFFFF, 10'd2, 4'd1, 4'd1, 1'b0},
        {16'h0010, 10'd1, 4'd2, 4'd2, 1'b0}
    };

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n && hold_req && !hold_prev) hold_rises <= hold_rises + 1;
        hold_prev <= hold_req;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            summary();
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_start(input logic [AW-1:0] a, input logic [CW-1:0] n);
        s_addr = a;
        s_cnt  = n;
        start  = 1'b1;
        tick();
        start  = 1'b0;
    endtask

    task automatic do_byte(input logic [AW-1:0] a, input int left, input int req_gap,
                           input int ack_gap, input bit keep, input logic [DW-1:0] dat,
                           input bit last);
        int n;
        for (int i = 0; i < req_gap; i++) begin
            chk("R3", "hold without request", hold_req, 0);
            tick();
        end
        chk("R3", "hold before request", hold_req, 0);
        per_req = 1'b1;
        tick();
        chk("R3", "hold after request", hold_req, 1);
        chk("R4", "write before grant", mem_wr, 0);
        for (int i = 0; i < ack_gap; i++) begin
            tick();
            chk("R4", "hold while waiting", hold_req, 1);
            chk("R4", "ack before grant", per_ack, 0);
            chk("R4", "read before grant", io_rd, 0);
        end
        io_data  = dat;
        hold_ack = 1'b1;
        tick();
        if (!keep) per_req = 1'b0;
        n = 0;
        while (mem_wr && n < 100) begin
            chk("R5", "address stable", mem_addr, a);
            chk("R5", "data passes", mem_data, dat);
            chk("R5", "ack with write", per_ack, 1);
            chk("R5", "read with write", io_rd, 1);
            n++;
            tick();
        end
        chk("R5", "write length", n, MC);
        chk("R7", "bus released", hold_req, 0);
        chk("R5", "data idle", mem_data, 0);
        chk("R6", "address step", mem_addr, AW'(a + 1'b1));
        chk("R6", "count step", remaining, left - 1);
        chk("R8", "terminal count", tc, last);
        hold_ack = 1'b0;
        tick();
        chk("R8", "done after byte", done, last);
        chk("R8", "busy after byte", busy, !last);
    endtask

    task automatic run_block(input logic [AW-1:0] a, input int n, input int rg,
                             input int ag, input bit keep);
        int r0;
        r0 = hold_rises;
        do_start(a, CW'(n));
        chk("R2", "busy", busy, 1);
        chk("R2", "address loaded", mem_addr, a);
        chk("R2", "count loaded", remaining, n);
        chk("R8", "done cleared", done, 0);
        for (int i = 0; i < n; i++)
            do_byte(AW'(a + i), n - i, rg, ag, keep, DW'(a[7:0] ^ (8'h5A + i)), i == n - 1);
        per_req = 1'b0;
        chk("R7", "hold requests per block", hold_rises - r0, n);
    endtask

    initial begin
        int r0;
        logic [34:0] v;
        // R1: reset state
        tick();
        chk("R1", "hold in reset", hold_req, 0);
        chk("R1", "write in reset", mem_wr, 0);
        rst_n = 1'b1;
        tick();
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R1", "tc", tc, 0);
        chk("R1", "ack", per_ack, 0);
        chk("R1", "read", io_rd, 0);

        // R3: idle ignores the peripheral
        per_req = 1'b1;
        tick();
        tick();
        chk("R3", "hold while idle", hold_req, 0);
        per_req = 1'b0;

        // main patterns from the table
        for (int k = 0; k < 6; k++) begin
            v = VEC[k];
            run_block(v[34:19], int'(v[18:9]), int'(v[8:5]), int'(v[4:1]), v[0]);
        end

        // R9: zero-count start
        r0 = hold_rises;
        do_start(16'h0300, '0);
        chk("R9", "busy", busy, 0);
        chk("R9", "done", done, 1);
        chk("R9", "tc", tc, 1);
        per_req = 1'b1;
        tick();
        tick();
        chk("R9", "no hold", hold_req, 0);
        chk("R9", "no hold edges", hold_rises - r0, 0);
        per_req = 1'b0;

        // R10: start while busy is ignored
        do_start(16'h0200, 10'd2);
        chk("R8", "done cleared by start", done, 0);
        per_req = 1'b1;
        tick();
        io_data  = 8'hC3;
        hold_ack = 1'b1;
        tick();
        per_req = 1'b0;
        do_start(16'h7777, 10'd5);
        chk("R10", "address kept", mem_addr, 16'h0200);
        chk("R10", "count kept", remaining, 2);
        for (int i = 0; i < 100 && mem_wr; i++) tick();
        hold_ack = 1'b0;
        chk("R10", "address after byte", mem_addr, 16'h0201);
        chk("R10", "count after byte", remaining, 1);
        tick();
        do_byte(16'h0201, 1, 0, 0, 1'b0, 8'h3C, 1'b1);

        // R1: reset during a transfer
        do_start(16'h0500, 10'd3);
        per_req = 1'b1;
        tick();
        hold_ack = 1'b1;
        tick();
        tick();
        chk("R5", "in transfer", mem_wr, 1);
        rst_n = 1'b0;
        #1;
        chk("R1", "write dropped by reset", mem_wr, 0);
        chk("R1", "hold dropped by reset", hold_req, 0);
        chk("R1", "busy dropped by reset", busy, 0);
        per_req  = 1'b0;
        hold_ack = 1'b0;
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1", "idle after reset", busy, 0);

        summary();
        $finish;
    end

endmodule